// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block owns the program counter of a 32-bit RISC core whose instructions are all four bytes long. On each cycle the decoder presents an instruction class, a condition code, a short immediate, a long immediate, two register operands with their indices, a destination index and the three saved return addresses. When the advance strobe is high, the unit commits the address of the next instruction into its PC register.

The unit covers straight-line flow, absolute jumps and calls within the current 256 MB region, PC-relative branches (unconditional and six-way conditional), register-indirect jumps and calls, and three kinds of return. Alongside the PC it registers a taken flag that a fetch front end can use to flush wrong-path words. It also registers a link-write request for calls and for the "read next PC" operation.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_o` is loaded with the parameter `RESET_VEC`, and `taken_o` and `link_we_o` are cleared.
- R2: At an edge where `adv_i` is low and `rst` is low, `pc_o` keeps its value, and `taken_o` and `link_we_o` go low, whatever the other inputs are.
- R3: Class 0 (sequential), and the unused class codes 11 to 15, set the next PC to PC + 4 (modulo 2^32) with `taken_o` low.
- R4: Class 1 (absolute jump) and class 2 (absolute call) set the next PC to {PC[31:28], `imm_j_i`, 2'b00}.
- R5: Class 3 (unconditional branch) sets the next PC to PC + 4 plus the sign-extended `imm_b_i` with its two low bits cleared. It is always taken, even when the offset is zero.
- R6: Class 4 (conditional branch) compares operand A with operand B. The condition codes are 0 = signed A >= B, 1 = signed A < B, 2 = A != B, 3 = A == B, 4 = unsigned A >= B and 5 = unsigned A < B. Codes 6 and 7 never hold. When the condition holds, the target is the R5 target. Otherwise the next PC is PC + 4 with `taken_o` low.
- R7: Class 5 (register jump) and class 6 (register call) set the next PC to operand A. For both compare and jump, an operand whose index input is 0 reads as zero regardless of its value input.
- R8: Class 7 loads the next PC from `ra_val_i`, class 8 from `ea_val_i` and class 9 from `ba_val_i`.
- R9: Classes 2 and 6 raise `link_we_o` with `link_idx_o` = 31 and `link_val_o` = PC + 4 of the calling instruction. No other class except class 10 raises `link_we_o`.
- R10: Class 10 (read next PC) leaves the flow sequential with `taken_o` low. It raises `link_we_o` with `link_idx_o` = `c_idx_i` and `link_val_o` = PC + 4, unless `c_idx_i` is 0, in which case `link_we_o` stays low.
- R11: `taken_o` is high after an advance exactly when the committed class is a non-sequential transfer: classes 1, 2, 3, 5, 6, 7, 8 and 9, and class 4 when its condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Commit the computed next PC at this edge |
| cls_i | input | 4 | Instruction class code |
| cond_i | input | 3 | Branch condition code |
| imm_b_i | input | 16 | Signed branch byte offset |
| imm_j_i | input | 26 | Absolute word index |
| a_idx_i | input | 5 | Register index of operand A |
| a_val_i | input | 32 | Value of operand A |
| b_idx_i | input | 5 | Register index of operand B |
| b_val_i | input | 32 | Value of operand B |
| c_idx_i | input | 5 | Destination index for class 10 |
| ra_val_i | input | 32 | Saved return address |
| ea_val_i | input | 32 | Saved exception-return address |
| ba_val_i | input | 32 | Saved break-return address |
| pc_o | output | 32 | Current program counter |
| taken_o | output | 1 | Last commit was a non-sequential transfer |
| link_we_o | output | 1 | Register write request from the last commit |
| link_idx_o | output | 5 | Register index to write |
| link_val_o | output | 32 | Value to write |

## Verification
The hardest situations to reach are those that depend on the PC itself. These are region splicing with non-zero upper PC bits, and sequential wrap past 0xFFFFFFFF. The PC is internal and can only be steered through its own transfers. The sweep therefore feeds the register-jump class with operand values such as 0xFFFFFFFF and 0x80000000 between the other classes. This carries the PC into high regions and onto the wrap boundary before absolute jumps and sequential steps run from there. The same sweep crosses every class with every condition code and with operand pairs at the signed and unsigned extremes. It also forces zero register indices, so that non-zero values must be masked.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int CLS_W  = 4;
  localparam int COND_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_SEQ   = 4'd0,
    CLS_JABS  = 4'd1,
    CLS_CALL  = 4'd2,
    CLS_BR    = 4'd3,
    CLS_BCND  = 4'd4,
    CLS_JREG  = 4'd5,
    CLS_CALLR = 4'd6,
    CLS_RET   = 4'd7,
    CLS_ERET  = 4'd8,
    CLS_BRET  = 4'd9,
    CLS_NXPC  = 4'd10
  } npc_cls_e;

  typedef enum logic [COND_W-1:0] {
    CND_GE  = 3'd0,
    CND_LT  = 3'd1,
    CND_NE  = 3'd2,
    CND_EQ  = 3'd3,
    CND_GEU = 3'd4,
    CND_LTU = 3'd5
  } npc_cond_e;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [COND_W-1:0] cond,
  output logic              hit
);
  localparam int NCOND = 1 << COND_W;

  logic [NCOND-1:0] hits;
  logic             eq, lt_s, lt_u;

  assign eq   = (a == b);
  assign lt_s = ($signed(a) < $signed(b));
  assign lt_u = (a < b);

  always_comb begin
    hits            = '0;
    hits[CND_GE]    = !lt_s;
    hits[CND_LT]    = lt_s;
    hits[CND_NE]    = !eq;
    hits[CND_EQ]    = eq;
    hits[CND_GEU]   = !lt_u;
    hits[CND_LTU]   = lt_u;
  end

  assign hit = hits[cond];
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 4,
  parameter int IMMB_W   = 16,
  parameter int ALIGN_W  = 2,
  localparam int IMMJ_W  = ADDR_W - REGION_W - ALIGN_W
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [IMMB_W-1:0] imm_b,
  input  logic [IMMJ_W-1:0] imm_j,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] rel_pc,
  output logic [ADDR_W-1:0] abs_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;
  localparam logic [ADDR_W-1:0] KEEP = ~((ADDR_W'(1) << ALIGN_W) - ADDR_W'(1));

  logic [ADDR_W-1:0] offs;

  assign offs   = {{(ADDR_W-IMMB_W){imm_b[IMMB_W-1]}}, imm_b} & KEEP;
  assign seq_pc = pc + STEP;
  assign rel_pc = seq_pc + offs;
  assign abs_pc = {pc[ADDR_W-1 -: REGION_W], imm_j, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/npc_link_sel.sv
module npc_link_sel
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter logic [IDX_W-1:0] RA_IDX = '1
) (
  input  logic [CLS_W-1:0]  cls,
  input  logic [IDX_W-1:0]  c_idx,
  input  logic [ADDR_W-1:0] seq_pc,
  output logic              we,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] val
);
  always_comb begin
    we  = 1'b0;
    idx = RA_IDX;
    case (cls)
      CLS_CALL, CLS_CALLR: we = 1'b1;
      CLS_NXPC: begin
        idx = c_idx;
        we  = (c_idx != '0);
      end
      default: we = 1'b0;
    endcase
  end

  assign val = seq_pc;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 4,
  parameter int IMMB_W   = 16,
  parameter int IDX_W    = 5,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_0000,
  localparam int ALIGN_W = 2,
  localparam int IMMJ_W  = ADDR_W - REGION_W - ALIGN_W,
  localparam logic [IDX_W-1:0] RA_IDX = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [IMMB_W-1:0] imm_b_i,
  input  logic [IMMJ_W-1:0] imm_j_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  input  logic [ADDR_W-1:0] a_val_i,
  input  logic [IDX_W-1:0]  b_idx_i,
  input  logic [ADDR_W-1:0] b_val_i,
  input  logic [IDX_W-1:0]  c_idx_i,
  input  logic [ADDR_W-1:0] ra_val_i,
  input  logic [ADDR_W-1:0] ea_val_i,
  input  logic [ADDR_W-1:0] ba_val_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [IDX_W-1:0]  link_idx_o,
  output logic [ADDR_W-1:0] link_val_o
);
  logic [ADDR_W-1:0] pc_q, a_eff, b_eff;
  logic [ADDR_W-1:0] seq_pc, rel_pc, abs_pc, nxt_pc;
  logic              cond_hit, nxt_tk;
  logic              lk_we;
  logic [IDX_W-1:0]  lk_idx;
  logic [ADDR_W-1:0] lk_val;
  logic              taken_q, link_we_q;
  logic [IDX_W-1:0]  link_idx_q;
  logic [ADDR_W-1:0] link_val_q;

  // index zero is hard-wired to zero
  assign a_eff = (a_idx_i == '0) ? '0 : a_val_i;
  assign b_eff = (b_idx_i == '0) ? '0 : b_val_i;

  npc_target_gen #(
    .ADDR_W(ADDR_W), .REGION_W(REGION_W), .IMMB_W(IMMB_W), .ALIGN_W(ALIGN_W)
  ) u_tgt (
    .pc(pc_q), .imm_b(imm_b_i), .imm_j(imm_j_i),
    .seq_pc(seq_pc), .rel_pc(rel_pc), .abs_pc(abs_pc)
  );

  npc_cond_eval #(.W(ADDR_W)) u_cmp (
    .a(a_eff), .b(b_eff), .cond(cond_i), .hit(cond_hit)
  );

  npc_link_sel #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RA_IDX(RA_IDX)) u_lnk (
    .cls(cls_i), .c_idx(c_idx_i), .seq_pc(seq_pc),
    .we(lk_we), .idx(lk_idx), .val(lk_val)
  );

  always_comb begin
    nxt_pc = seq_pc;
    nxt_tk = 1'b0;
    case (cls_i)
      CLS_JABS, CLS_CALL: begin nxt_pc = abs_pc;   nxt_tk = 1'b1; end
      CLS_BR:             begin nxt_pc = rel_pc;   nxt_tk = 1'b1; end
      CLS_BCND: if (cond_hit) begin nxt_pc = rel_pc; nxt_tk = 1'b1; end
      CLS_JREG, CLS_CALLR: begin nxt_pc = a_eff;   nxt_tk = 1'b1; end
      CLS_RET:            begin nxt_pc = ra_val_i; nxt_tk = 1'b1; end
      CLS_ERET:           begin nxt_pc = ea_val_i; nxt_tk = 1'b1; end
      CLS_BRET:           begin nxt_pc = ba_val_i; nxt_tk = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= RESET_VEC;
      taken_q    <= 1'b0;
      link_we_q  <= 1'b0;
      link_idx_q <= '0;
      link_val_q <= '0;
    end else if (adv_i) begin
      pc_q       <= nxt_pc;
      taken_q    <= nxt_tk;
      link_we_q  <= lk_we;
      link_idx_q <= lk_idx;
      link_val_q <= lk_val;
    end else begin
      taken_q    <= 1'b0;
      link_we_q  <= 1'b0;
    end
  end

  assign pc_o       = pc_q;
  assign taken_o    = taken_q;
  assign link_we_o  = link_we_q;
  assign link_idx_o = link_idx_q;
  assign link_val_o = link_val_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> ($stable(pc_q) && !taken_q && !link_we_q));

  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    (adv_i && cls_i == CLS_SEQ) |=> (!taken_q && pc_q == $past(pc_q) + 32'd4));

  p_eq_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (adv_i && cls_i == CLS_BCND && cond_i == CND_EQ && a_eff == b_eff) |=> taken_q);

  p_call_link_r9: assert property (@(posedge clk) disable iff (rst)
    (taken_q && link_we_q) |-> (link_idx_q == RA_IDX));

  p_nxpc_r10: assert property (@(posedge clk) disable iff (rst)
    (adv_i && cls_i == CLS_NXPC) |=>
      (!taken_q && link_we_q == ($past(c_idx_i) != '0) && link_val_q == $past(pc_q) + 32'd4));

  p_no_zero_dst_r10: assert property (@(posedge clk) disable iff (rst)
    link_we_q |-> (link_idx_q != '0));
endmodule

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
  localparam logic [31:0] RV = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_i = 1'b0;
  logic [3:0]  cls_i = '0;
  logic [2:0]  cond_i = '0;
  logic [15:0] imm_b_i = '0;
  logic [25:0] imm_j_i = '0;
  logic [4:0]  a_idx_i = '0, b_idx_i = '0, c_idx_i = '0;
  logic [31:0] a_val_i = '0, b_val_i = '0;
  logic [31:0] ra_val_i = '0, ea_val_i = '0, ba_val_i = '0;
  logic [31:0] pc_o, link_val_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] mpc;

  always #4 clk = ~clk;

  npc_unit #(.RESET_VEC(RV)) dut (
    .clk(clk), .rst(rst), .adv_i(adv_i), .cls_i(cls_i), .cond_i(cond_i),
    .imm_b_i(imm_b_i), .imm_j_i(imm_j_i), .a_idx_i(a_idx_i), .a_val_i(a_val_i),
    .b_idx_i(b_idx_i), .b_val_i(b_val_i), .c_idx_i(c_idx_i),
    .ra_val_i(ra_val_i), .ea_val_i(ea_val_i), .ba_val_i(ba_val_i),
    .pc_o(pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o), .link_val_o(link_val_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int c);
    case (c)
      1, 2:    return "R4";
      3:       return "R5";
      4:       return "R6";
      5, 6:    return "R7";
      7, 8, 9: return "R8";
      10:      return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic step(input int c, input int cd, input logic [31:0] av,
                      input logic [31:0] bv, input bit z, input int n);
    logic [31:0] sa, sb, seq, rel, npc;
    logic        tk, hit, we;
    logic [4:0]  ix;
    cls_i    = 4'(c);
    cond_i   = 3'(cd);
    imm_b_i  = 16'(n * 1237) ^ 16'h8003;
    imm_j_i  = 26'(n * 40503 + 3);
    a_idx_i  = z ? 5'd0 : 5'd7;
    b_idx_i  = z ? 5'd0 : 5'd9;
    c_idx_i  = ((n % 4) == 0) ? 5'd0 : 5'(n);
    a_val_i  = av;
    b_val_i  = bv;
    ra_val_i = 32'hA000_0000 + 32'(n * 4);
    ea_val_i = 32'h5000_0000 ^ 32'(n * 8);
    ba_val_i = 32'hC000_0010 + 32'(n * 12);
    adv_i    = 1'b1;
    sa  = z ? 32'd0 : av;
    sb  = z ? 32'd0 : bv;
    seq = mpc + 32'd4;
    rel = seq + ({{16{imm_b_i[15]}}, imm_b_i} & 32'hFFFF_FFFC);
    case (cd)
      0: hit = $signed(sa) >= $signed(sb);
      1: hit = $signed(sa) <  $signed(sb);
      2: hit = sa != sb;
      3: hit = sa == sb;
      4: hit = sa >= sb;
      5: hit = sa <  sb;
      default: hit = 1'b0;
    endcase
    npc = seq; tk = 1'b1;
    case (c)
      1, 2: npc = {mpc[31:28], imm_j_i, 2'b00};
      3:    npc = rel;
      4:    begin npc = hit ? rel : seq; tk = hit; end
      5, 6: npc = sa;
      7:    npc = ra_val_i;
      8:    npc = ea_val_i;
      9:    npc = ba_val_i;
      default: tk = 1'b0;
    endcase
    we = (c == 2) || (c == 6) || (c == 10 && c_idx_i != 0);
    ix = (c == 10) ? c_idx_i : 5'd31;
    @(posedge clk);
    @(negedge clk);
    chk(tag_of(c), "pc", pc_o, npc);
    chk("R11", "taken", 32'(taken_o), 32'(tk));
    chk((c == 10) ? "R10" : "R9", "link_we", 32'(link_we_o), 32'(we));
    if (we) begin
      chk((c == 10) ? "R10" : "R9", "link_idx", 32'(link_idx_o), 32'(ix));
      chk((c == 10) ? "R10" : "R9", "link_val", link_val_o, seq);
    end
    mpc = npc;
  endtask

  task automatic idle(input int n);
    adv_i   = 1'b0;
    cls_i   = 4'(n % 11);
    a_idx_i = 5'd3;
    a_val_i = 32'h1234_5678;
    c_idx_i = 5'd4;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "pc", pc_o, mpc);
    chk("R2", "taken", 32'(taken_o), 32'd0);
    chk("R2", "link_we", 32'(link_we_o), 32'd0);
  endtask

  logic [31:0] vals [6];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'hF000_1234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "pc", pc_o, RV);
    chk("R1", "taken", 32'(taken_o), 32'd0);
    chk("R1", "link_we", 32'(link_we_o), 32'd0);
    mpc = RV;
    begin
      int n;
      n = 0;
      for (int c = 0; c < 16; c++)
        for (int cd = 0; cd < 8; cd++)
          for (int ai = 0; ai < 6; ai++)
            for (int bi = 0; bi < 6; bi++)
              for (int z = 0; z < 2; z++) begin
                n++;
                step(c, cd, vals[ai], vals[bi], z[0], n);
                // steer PC into high regions and onto the wrap boundary
                if ((n % 5) == 0) step(5, 0, vals[(n / 5) % 6], 32'd0, 1'b0, n + 1);
                if ((n % 7) == 0) idle(n);
              end
      // offset-zero unconditional branch is still taken (R5)
      step(0, 0, 32'd0, 32'd0, 1'b1, 16'h3FFF);
      cls_i = 4'd3; imm_b_i = 16'h0000; adv_i = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R5", "pc zero offset", pc_o, mpc + 32'd4);
      chk("R5", "taken zero offset", 32'(taken_o), 32'd1);
      mpc = mpc + 32'd4;
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule